// File: doc/BRIEF.md
# Load Switch Drive Command Path with Turn-On Delay

This block produces the final on/off drive for a single load switch. A command bit held in a register is merged with an external direct-input pin when direct control is enabled; a mode bit picks whether the two are merged by AND or by OR. With direct control disabled, only the command bit counts.

When the serial command bit goes from 0 to 1, the serial contribution stays masked for a programmable time. That time is set by a 3-bit code in steps of 75 timebase ticks, where one tick is a 1 ms pulse. A turn-on caused by the pin is never delayed. Turn-off is never delayed. In fail-safe mode the delay setting is ignored. The drive output is registered on the system clock.

Top module: `out_cmd_path`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset, drive_o is 0 and no turn-on delay is pending.
- R2: With direct_en_i = 0, drive_o follows cmd_i with one clock of latency (delay code 000), and pin_i has no effect.
- R3: With direct_en_i = 1 and and_mode_i = 1, the effective command is pin_i AND the serial command.
- R4: With direct_en_i = 1 and and_mode_i = 0, the effective command is pin_i OR the serial command.
- R5: A 0-to-1 change of cmd_i with code N (N = 1..7) and fail-safe off masks the serial command for N*75 tick_i pulses. These are counted from the clock after the rising edge. drive_o rises one clock after the clock that samples the last of those pulses. Without tick_i pulses the mask is held.
- R6: A turn-on caused by pin_i (cmd_i already high with no delay pending in AND mode, or OR mode) reaches drive_o one clock later, with no delay.
- R7: When cmd_i is 0 and the pin does not force the output on, drive_o is 0 one clock later. cmd_i falling during a delay cancels it, and the next rise starts the full delay again.
- R8: While failsafe_i is 1, the delay code has no effect: a cmd_i rise reaches drive_o one clock later, and a pending delay is dropped at once.
- R9: Delay code 000 (the value after reset in the register file) gives no delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 1 | Register-held serial on/off command |
| pin_i | input | 1 | Direct input pin |
| direct_en_i | input | 1 | 1 = merge the pin with the command |
| and_mode_i | input | 1 | Merge mode: 1 = AND, 0 = OR |
| delay_code_i | input | 3 | Turn-on delay, code × 75 ticks |
| failsafe_i | input | 1 | Fail-safe mode; bypasses the delay |
| tick_i | input | 1 | 1 ms timebase pulse, one clock wide |
| drive_o | output | 1 | Registered switch drive |

## Verification
The delay timer and the command path can act in the same cycle. The tick that completes a delay can land on the same clock as cmd_i falling, as fail-safe being raised, or as a pin edge. The bench forces this overlap. It lowers cmd_i at offsets that sweep across the completing tick, and it moves the pin while a delay is still pending. A behavioural model that counts ticks in integers judges drive_o on every clock, and directed tick counts confirm the exact delay lengths.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int unsigned DEF_STEP_TICKS = 75;
  localparam int unsigned DEF_CODE_W     = 3;

  function automatic logic merge_cmd(logic en, logic and_m, logic pin, logic cmd);
    if (!en) return cmd;
    return and_m ? (pin & cmd) : (pin | cmd);
  endfunction
endpackage

// File: rtl/ocp_delay.sv
module ocp_delay #(
  parameter int unsigned STEP_TICKS = ocp_pkg::DEF_STEP_TICKS,
  parameter int unsigned CODE_W     = ocp_pkg::DEF_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              failsafe_i,
  input  logic              tick_i,
  output logic              block_o
);
  localparam int unsigned MAX_TICKS = STEP_TICKS * ((1 << CODE_W) - 1);
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic             cmd_q, pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, target;
  logic             rise, start;

  assign target  = CNT_W'(code_i) * CNT_W'(STEP_TICKS);
  assign cnt_inc = cnt_q + 1'b1;
  assign rise    = cmd_i & ~cmd_q;
  assign start   = rise & (code_i != '0) & ~failsafe_i;
  assign block_o = ~failsafe_i & (pend_q | start);

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (failsafe_i || !cmd_i) begin
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (rise) begin
      pend_d = start;
      cnt_d  = '0;
    end else if (pend_q && tick_i) begin
      // >= covers a code lowered mid-delay
      if (cnt_inc >= target) begin
        pend_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cmd_q  <= cmd_i;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  // R5
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && cmd_i && !failsafe_i && !tick_i |=> pend_q);
  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_TICKS));
  // R7
  cancel_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i |=> !pend_q && cnt_q == '0);
  // R8
  failsafe_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failsafe_i |=> !pend_q);
endmodule

// File: rtl/ocp_merge.sv
module ocp_merge (
  input  logic direct_en_i,
  input  logic and_mode_i,
  input  logic pin_i,
  input  logic cmd_i,
  output logic eff_o
);
  assign eff_o = ocp_pkg::merge_cmd(direct_en_i, and_mode_i, pin_i, cmd_i);
endmodule

// File: rtl/out_cmd_path.sv
module out_cmd_path #(
  parameter int unsigned STEP_TICKS = ocp_pkg::DEF_STEP_TICKS,
  parameter int unsigned CODE_W     = ocp_pkg::DEF_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic              pin_i,
  input  logic              direct_en_i,
  input  logic              and_mode_i,
  input  logic [CODE_W-1:0] delay_code_i,
  input  logic              failsafe_i,
  input  logic              tick_i,
  output logic              drive_o
);
  logic block, cmd_gated, eff, drive_q;

  ocp_delay #(.STEP_TICKS(STEP_TICKS), .CODE_W(CODE_W)) u_delay (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd_i),
    .code_i    (delay_code_i),
    .failsafe_i(failsafe_i),
    .tick_i    (tick_i),
    .block_o   (block)
  );

  // delay masks only the serial contribution
  assign cmd_gated = cmd_i & ~block;

  ocp_merge u_merge (
    .direct_en_i(direct_en_i),
    .and_mode_i (and_mode_i),
    .pin_i      (pin_i),
    .cmd_i      (cmd_gated),
    .eff_o      (eff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_q <= 1'b0;
    else         drive_q <= eff;
  end
  assign drive_o = drive_q;

  // R3
  and_pin_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_en_i && and_mode_i && !pin_i |=> !drive_o);
  // R4
  or_pin_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_en_i && !and_mode_i && pin_i |=> drive_o);
  // R7
  off_undelayed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i && !(direct_en_i && pin_i) |=> !drive_o);
  // R8
  failsafe_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failsafe_i && cmd_i && !direct_en_i |=> drive_o);
endmodule

// File: tb/out_cmd_path_tb.sv
`timescale 1ns/1ps
module out_cmd_path_tb;
  logic clk = 0, rst_ni = 0;
  logic cmd = 0, pin = 0, den = 0, andm = 0, fs = 0, tick = 0;
  logic [2:0] code = 0;
  logic drive;
  int checks = 0, errors = 0, tick_seen = 0, cyc = 0;
  bit tick_run = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  out_cmd_path u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd), .pin_i(pin),
    .direct_en_i(den), .and_mode_i(andm), .delay_code_i(code),
    .failsafe_i(fs), .tick_i(tick), .drive_o(drive)
  );

  // behavioural reference
  bit m_prev = 0, m_pend = 0, exp_drive = 0;
  int m_cnt = 0;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_prev = 0; m_pend = 0; m_cnt = 0; exp_drive = 0;
    end else begin
      bit rise, masked, ser, eff;
      rise   = cmd && !m_prev;
      masked = !fs && (m_pend || (rise && code != 0));
      ser    = cmd && !masked;
      eff    = !den ? ser : (andm ? (pin && ser) : (pin || ser));
      exp_drive = eff;
      if (fs || !cmd) begin m_pend = 0; m_cnt = 0; end
      else if (rise) begin m_pend = (code != 0); m_cnt = 0; end
      else if (m_pend && tick) begin
        m_cnt++;
        if (m_cnt >= int'(code) * 75) begin m_pend = 0; m_cnt = 0; end
      end
      m_prev = cmd;
    end
  end

  always @(posedge clk) begin
    if (tick) tick_seen++;
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (rst_ni) begin
    checks++;
    if (drive !== exp_drive) begin
      errors++;
      $display("FAIL %s cycle %0d: drive actual=%b expected=%b", cur_req, cyc, drive, exp_drive);
    end
  end

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk); #1;
      tick = tick_run && (ph == 2);
      ph = (ph + 1) % 3;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // rise cmd, count ticks until drive goes high
  task automatic measure(string req, int exp_ticks);
    int s;
    cmd = 1;
    cycles(1);
    s = tick_seen;
    for (int i = 0; i < 3000 && !drive; i++) cycles(1);
    chk_int(req, tick_seen - s, exp_ticks);
    cmd = 0; cycles(2);
  endtask

  task automatic wait_ticks(int n);
    int s = tick_seen;
    while (tick_seen - s < n) cycles(1);
  endtask

  initial begin
    #1;
    cycles(2);
    chk("R1", drive, 0);
    rst_ni = 1;
    cycles(1);
    chk("R1", drive, 0);
    tick_run = 1;

    cur_req = "R2";
    cmd = 1; pin = 0; cycles(1); chk("R2", drive, 1);
    pin = 1; cmd = 0; cycles(1); chk("R2", drive, 0);
    cmd = 1; cycles(1); chk("R9", drive, 1);
    cmd = 0; pin = 0; cycles(2);

    cur_req = "R5";
    code = 1; measure("R5 code1", 75);
    code = 7; measure("R5 code7", 525);
    code = 3; tick_run = 0; cmd = 1; cycles(300);
    chk("R5 no tick holds", drive, 0);
    tick_run = 1; cmd = 0; cycles(2);

    cur_req = "R7";
    code = 2; cmd = 1; cycles(1); wait_ticks(100);
    cmd = 0; cycles(1); chk("R7 off", drive, 0);
    measure("R7 restart", 150);
    for (int off = 0; off < 4; off++) begin
      code = 1; cmd = 1; cycles(1); wait_ticks(74);
      cycles(off); cmd = 0; cycles(2);
      chk("R7 cancel sweep", drive, 0);
    end

    cur_req = "R3";
    den = 1; andm = 1; code = 0;
    cmd = 1; pin = 0; cycles(1); chk("R3", drive, 0);
    pin = 1; cycles(1); chk("R3", drive, 1);
    cmd = 0; cycles(1); chk("R3", drive, 0);

    cur_req = "R6";
    code = 3; pin = 1; cmd = 1; cycles(10); chk("R6 serial delayed", drive, 0);
    cmd = 0; pin = 0; cycles(2);
    cmd = 1; cycles(1); wait_ticks(230); chk("R6 pin low", drive, 0);
    pin = 1; cycles(1); chk("R6 pin on", drive, 1);
    pin = 0; cmd = 0; cycles(2);

    cur_req = "R4";
    andm = 0; code = 4; pin = 1; cycles(1); chk("R4 pin", drive, 1);
    pin = 0; cmd = 1; cycles(5); chk("R4 delayed", drive, 0);
    pin = 1; cycles(1); chk("R6 or pin", drive, 1);
    pin = 0; cycles(1); chk("R4 still pending", drive, 0);
    cmd = 0; den = 0; cycles(2);

    cur_req = "R8";
    code = 7; fs = 1; cmd = 1; cycles(1); chk("R8 bypass", drive, 1);
    cmd = 0; fs = 0; cycles(2);
    cmd = 1; cycles(20); chk("R8 pending", drive, 0);
    fs = 1; cycles(1); chk("R8 drop", drive, 1);
    fs = 0; cycles(5); chk("R8 no rearm", drive, 1);
    cmd = 0; cycles(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule